// File: doc/BRIEF.md
# Gated Period Measurement Counter

This block measures one period of an external signal. Software issues a start strobe, which clears the counter and arms the gate. The gate opens on the next rising edge of the chosen external pin and closes on the rising edge after that. While the gate is open, a 16-bit counter counts single-cycle reference ticks at the selected rate.

A measurement can be stopped early in two ways. Forcing the gate off ends it. Deselecting both pins also stops counting, but leaves the gate open. A second start strobe during a measurement throws the running count away and arms the gate again.

The external pins are brought in through two-flop synchronizers. All logic runs on one system clock with a synchronous active-high reset.

Top module: `period_gate_counter`

## Requirements
- R1: After reset, `gate_o`, `done_o` and `ovf_o` are 0 and `count_o` is 0.
- R2: A start strobe arms the gate. The gate then opens on the first rising edge of the selected pin and closes on the next rising edge. At that point `count_o` equals the number of selected reference ticks seen while the gate was open.
- R3: `rate_sel_i` chooses the reference. 00 selects `tick_slow_i`, 01 selects `tick_mid_i`, and 10 or 11 select `tick_fast_i`. Ticks on the inputs that are not selected have no effect on the count.
- R4: `pin_sel_i` chooses the gating pin. 01 selects `sig_a_i`, 10 or 11 select `sig_b_i`, and 00 selects no pin. Edges on the pin that is not selected neither open nor close the gate.
- R5: A start strobe while the gate is open clears the count and `done_o` and returns the gate to armed. A new period then begins at the next rising edge.
- R6: While `gate_ctl_i` is 11, the gate is forced closed. If the gate was open, `done_o` is set and the count is frozen. Start strobes and ticks are ignored while the force is held.
- R7: With `pin_sel_i` at 00, an open gate stays open (`gate_o` stays 1) but the count does not change.
- R8: `done_o` is set when the gate closes and is cleared by the next accepted start strobe. An accepted start also clears `count_o`.
- R9: The counter saturates at 0xFFFF instead of wrapping, and `ovf_o` is set when a tick arrives while the count is saturated. `ovf_o` is cleared by an accepted start.
- R10: `gate_o` is 1 from an accepted start until the gate closes or is forced off. It is a busy indication and does not mark the open interval exactly.
- R11: The count changes by at most one per clock, and only while the gate is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, one cycle |
| pin_sel_i | input | 2 | Gating pin select |
| gate_ctl_i | input | 2 | 11 forces the gate closed |
| rate_sel_i | input | 2 | Reference rate select |
| tick_slow_i | input | 1 | Slow reference tick enable |
| tick_mid_i | input | 1 | Middle reference tick enable |
| tick_fast_i | input | 1 | Fast reference tick enable |
| sig_a_i | input | 1 | External signal A, asynchronous |
| sig_b_i | input | 1 | External signal B, asynchronous |
| gate_o | output | 1 | Busy or gate status |
| done_o | output | 1 | Measurement finished |
| ovf_o | output | 1 | Count saturated during the measurement |
| count_o | output | 16 | Measured count |

## Verification
The assertions assume that `start_i` and the tick inputs are clean one-cycle enables in the clock domain. They also assume that `pin_sel_i`, `rate_sel_i` and `gate_ctl_i` change only between clock edges. The bench drives every input on the falling edge. It holds each external pin level for several cycles, so that each intended edge passes through the synchronizer exactly once. Ticks are sent only once the gate has had time to open, so the expected count is the number of ticks the bench issued.

// File: rtl/period_gate_counter.sv
module period_gate_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       pin_sel_i,
  input  logic [1:0]       gate_ctl_i,
  input  logic [1:0]       rate_sel_i,
  input  logic             tick_slow_i,
  input  logic             tick_mid_i,
  input  logic             tick_fast_i,
  input  logic             sig_a_i,
  input  logic             sig_b_i,
  output logic             gate_o,
  output logic             done_o,
  output logic             ovf_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_OPEN} gate_st_t;
  gate_st_t st_q;

  logic [2:0] a_sh, b_sh;
  logic       rise, tick, force_off, start_ok, inc;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sh <= '0;
      b_sh <= '0;
    end else begin
      a_sh <= {a_sh[1:0], sig_a_i};
      b_sh <= {b_sh[1:0], sig_b_i};
    end
  end

  always_comb begin
    unique case (pin_sel_i)
      2'b00:   rise = 1'b0;
      2'b01:   rise = a_sh[1] & ~a_sh[2];
      default: rise = b_sh[1] & ~b_sh[2];
    endcase
    unique case (rate_sel_i)
      2'b00:   tick = tick_slow_i;
      2'b01:   tick = tick_mid_i;
      default: tick = tick_fast_i;
    endcase
  end

  assign force_off = &gate_ctl_i;
  assign start_ok  = start_i & ~force_off;
  assign inc       = (st_q == ST_OPEN) & tick & (|pin_sel_i) & ~force_off & ~start_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else if (force_off) begin
      if (st_q == ST_OPEN) done_o <= 1'b1;
      st_q <= ST_IDLE;
    end else if (start_ok) begin
      st_q   <= ST_ARMED;
      cnt_q  <= '0;
      done_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      if (inc) begin
        if (cnt_q == CNT_MAX) ovf_o <= 1'b1;
        else                  cnt_q <= cnt_q + 1'b1;
      end
      if (rise && st_q == ST_ARMED) st_q <= ST_OPEN;
      if (rise && st_q == ST_OPEN) begin
        st_q   <= ST_IDLE;
        done_o <= 1'b1;
      end
    end
  end

  assign gate_o  = (st_q != ST_IDLE);
  assign count_o = cnt_q;

  AST_FORCE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    force_off |=> !gate_o); // R6
  AST_FORCE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    force_off |=> $stable(count_o)); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> (count_o == '0) && !done_o && !ovf_o && gate_o); // R8
  AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (count_o == CNT_MAX) && !start_ok |=> count_o == CNT_MAX); // R9
  AST_OVF_AT_MAX: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> count_o == CNT_MAX); // R9
  AST_DESEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (pin_sel_i == 2'b00) && !start_ok |=> $stable(count_o)); // R7
  AST_DESEL_STAYS_OPEN: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OPEN) && (pin_sel_i == 2'b00) && !force_off |=> gate_o); // R7
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    !start_ok |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1)); // R11
  AST_NO_COUNT_SHUT: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_OPEN) && !start_ok |=> $stable(count_o)); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> !gate_o); // R10
endmodule

// File: tb/sim_period_gate_counter.sv
module sim_period_gate_counter;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  // {pin_sel, rate_sel, ticks, noise}
  localparam logic [27:0] VEC [NV] = '{
    {2'b01, 2'b00, 16'd5,  8'd1},
    {2'b10, 2'b01, 16'd12, 8'd1},
    {2'b01, 2'b10, 16'd0,  8'd0},
    {2'b11, 2'b11, 16'd37, 8'd1},
    {2'b01, 2'b01, 16'd1,  8'd0}
  };

  logic clk = 0, rst = 1, start_i = 0;
  logic [1:0] pin_sel_i = 2'b01, gate_ctl_i = 2'b00, rate_sel_i = 2'b00;
  logic tick_slow_i = 0, tick_mid_i = 0, tick_fast_i = 0, sig_a_i = 0, sig_b_i = 0;
  logic gate_o, done_o, ovf_o;
  logic [15:0] count_o;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  period_gate_counter u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe;
    start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic set_sig(input logic sel_b, input logic v);
    if (sel_b) sig_b_i = v; else sig_a_i = v;
    wait_n(5);
  endtask

  task automatic ticks(input logic [1:0] rs, input int n, input logic noise);
    for (int i = 0; i < n; i++) begin
      tick_slow_i = (rs == 2'b00) | noise;
      tick_mid_i  = (rs == 2'b01) | noise;
      tick_fast_i = rs[1] | noise;
      @(negedge clk);
      tick_slow_i = 0; tick_mid_i = 0; tick_fast_i = 0;
      if (noise) begin
        tick_slow_i = (rs != 2'b00);
        tick_mid_i  = (rs != 2'b01);
        tick_fast_i = !rs[1];
      end
      @(negedge clk);
      tick_slow_i = 0; tick_mid_i = 0; tick_fast_i = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_n(3);
    chk("R1 gate", gate_o, 0); chk("R1 done", done_o, 0);
    chk("R1 ovf", ovf_o, 0);   chk("R1 count", count_o, 0);
    rst = 0; wait_n(2);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] ps, rs;
      ps = VEC[v][27:26]; rs = VEC[v][25:24];
      pin_sel_i = ps; rate_sel_i = rs;
      set_sig(ps[1], 0);
      strobe; wait_n(1);
      chk("R10 busy after start", gate_o, 1);
      chk("R8 done cleared", done_o, 0);
      set_sig(!ps[1], 1); set_sig(!ps[1], 0);   // R4 other pin ignored
      chk("R4 other pin no close", done_o, 0);
      set_sig(ps[1], 1);
      ticks(rs, int'(VEC[v][23:8]), VEC[v][0]);
      chk("R3 not done yet", done_o, 0);
      set_sig(ps[1], 0); set_sig(ps[1], 1);
      chk("R2 done", done_o, 1);
      chk("R2 R3 count", count_o, {16'h0, VEC[v][23:8]});
      chk("R10 idle", gate_o, 0);
    end

    // R5 restart while open
    pin_sel_i = 2'b01; rate_sel_i = 2'b00;
    set_sig(0, 0); strobe; set_sig(0, 1);
    ticks(2'b00, 7, 0);
    strobe; wait_n(1);
    chk("R5 count cleared", count_o, 0);
    chk("R5 still busy", gate_o, 1);
    set_sig(0, 0); set_sig(0, 1);
    ticks(2'b00, 3, 0);
    chk("R5 no early done", done_o, 0);
    set_sig(0, 0); set_sig(0, 1);
    chk("R5 fresh count", count_o, 3);
    chk("R5 done", done_o, 1);

    // R6 force off
    set_sig(0, 0); strobe; set_sig(0, 1);
    ticks(2'b00, 4, 0);
    gate_ctl_i = 2'b11; wait_n(2);
    chk("R6 gate closed", gate_o, 0);
    chk("R6 done", done_o, 1);
    ticks(2'b00, 3, 0);
    strobe; wait_n(1);
    chk("R6 start ignored", done_o, 1);
    chk("R6 count frozen", count_o, 4);
    gate_ctl_i = 2'b00; wait_n(1);
    ticks(2'b00, 2, 0);
    chk("R6 stays closed", count_o, 4);

    // R7 deselect
    set_sig(0, 0); strobe; set_sig(0, 1);
    ticks(2'b00, 3, 0);
    pin_sel_i = 2'b00;
    ticks(2'b00, 5, 0);
    set_sig(0, 0); set_sig(0, 1);
    chk("R7 count frozen", count_o, 3);
    chk("R7 gate open", gate_o, 1);
    chk("R7 no done", done_o, 0);
    pin_sel_i = 2'b01;
    set_sig(0, 0); set_sig(0, 1);
    chk("R7 closes after reselect", done_o, 1);
    chk("R7 final count", count_o, 3);

    // R9 saturation
    set_sig(0, 0); strobe; set_sig(0, 1);
    rate_sel_i = 2'b10; tick_fast_i = 1;
    wait_n(65540);
    tick_fast_i = 0;
    set_sig(0, 0); set_sig(0, 1);
    chk("R9 saturated", count_o, 16'hFFFF);
    chk("R9 ovf", ovf_o, 1);
    strobe; wait_n(1);
    chk("R9 ovf cleared", ovf_o, 0);
    chk("R8 count cleared", count_o, 0);

    rst = 1; wait_n(2);
    chk("R1 reset again gate", gate_o, 0);
    chk("R1 reset again count", count_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule